// File: doc/BRIEF.md
# Embedded Operation Status Reporter

This block decides what a host read returns while an embedded program or erase runs inside a flash array controller. Each cycle it looks at the operation state (busy, suspended, program or erase, failed) and at whether the read address lies in a sector marked for erase. It then returns either the array word, which it passes through unchanged, or a status word built from polling and toggle bits. It also drives a ready/busy output in open-drain form.

Five states run the block. READY: no operation; reads return array data. PROG: a program is running. ERASE: an erase is running. SUSP: an erase is on hold. FAIL: the operation timed out; the block holds here until reset. The transitions are as follows. READY goes to PROG on busy with program type, and to ERASE on busy with erase type. PROG goes to FAIL on the fail flag. Otherwise, when busy drops, PROG goes to SUSP if suspend is still set and to READY if it is not. ERASE goes to FAIL on the fail flag, to SUSP on suspend, and to READY when busy drops. SUSP goes to PROG on busy with program type (a program inside the suspend), to ERASE when suspend clears with busy and erase type (resume), and to READY when both suspend and busy are low. FAIL leaves only through reset. The state register follows its inputs one clock later. A read strobe returns its word on `rd_data` one clock later, together with `rd_valid`.

Top module: `op_status_reporter`

## Requirements
- R1: After reset, `rd_valid` is 0 and `rb_en_n` is 1. Both toggle bits start at 0, so the first status read returns bit 6 = 0 and bit 2 = 0. `rb_zero` is always 0.
- R2: A read strobe gives `rd_valid`=1 one cycle later. In READY, `rd_data` equals the `arr_data` sampled with the strobe and `rd_is_status` is 0.
- R3: `rb_en_n` goes low in the cycle after busy is seen and stays low through PROG, ERASE and FAIL. It is high in READY and in SUSP.
- R4: In PROG, every read returns status (`rd_is_status`=1). Bit 7 is the complement of `tgt_bit`, and bits 5 and 3 are 0.
- R5: Bit 6 of the status word inverts after every read made in PROG, ERASE or FAIL. The value returned is the one before the inversion.
- R6: In ERASE, every read returns status with bit 7 = 0 and bit 3 = `window_closed`.
- R7: Bit 2 inverts only after reads with `sel_erase`=1 made in ERASE or SUSP. All other reads return it unchanged.
- R8: In SUSP, reads with `sel_erase`=0 return array data. Reads with `sel_erase`=1 return status with bit 7 = 1 and bit 3 = `window_closed`, and leave bit 6 frozen.
- R9: `op_fail` in PROG or ERASE enters FAIL. There, every read returns status with bit 5 = 1, and for a failed program bit 7 is the complement of `tgt_bit`. The block stays in FAIL with `rb_en_n` low after busy and fail drop, until reset.
- R10: Once busy drops with no suspend, reads return true array data.
- R11: A program started in SUSP returns status on all reads and then goes back to SUSP. Clearing suspend with busy and erase type resumes ERASE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_busy | input | 1 | Embedded operation running |
| op_is_erase | input | 1 | 1 = erase, 0 = program |
| op_suspended | input | 1 | Erase on hold |
| op_fail | input | 1 | Operation timed out |
| tgt_bit | input | 1 | Bit 7 of the data being programmed |
| window_closed | input | 1 | Sector-erase accept window closed |
| rd_strobe | input | 1 | A host read occurs this cycle |
| sel_erase | input | 1 | Read address lies in an erase-selected sector |
| arr_data | input | DATA_W | Array word for the read address |
| rd_data | output | DATA_W | Returned word |
| rd_valid | output | 1 | `rd_data` holds the answer to the last strobe |
| rd_is_status | output | 1 | Returned word is status, not array data |
| rb_en_n | output | 1 | Ready/busy drive enable, low pulls the line low (busy) |
| rb_zero | output | 1 | Ready/busy data line, constant 0 |

## Verification
The read decision is tried in every state, with both values of `sel_erase` and with distinct array words. This shows whether array pass-through and status substitution are chosen by state and address and not by state alone. Back-to-back reads with selected and unselected addresses separate the two toggle bits: bit 6 flips on every busy read, while bit 2 flips only on selected erase reads and freezes during suspend. Flipping `tgt_bit` and `window_closed` between reads shows that bits 7 and 3 follow live inputs. Dropping busy and fail after a timeout shows that the failure state is sticky.

// File: rtl/op_status_pkg.sv
package op_status_pkg;
    typedef enum logic [2:0] {
        ST_READY = 3'd0,
        ST_PROG  = 3'd1,
        ST_ERASE = 3'd2,
        ST_SUSP  = 3'd3,
        ST_FAIL  = 3'd4
    } rpt_state_t;

    localparam int BIT_POLL    = 7;
    localparam int BIT_TOGGLE  = 6;
    localparam int BIT_FAIL    = 5;
    localparam int BIT_WINDOW  = 3;
    localparam int BIT_ETOGGLE = 2;
    localparam int MIN_W       = 8;
endpackage

// File: rtl/opst_fsm.sv
module opst_fsm
    import op_status_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_busy,
    input  logic       op_is_erase,
    input  logic       op_suspended,
    input  logic       op_fail,
    output rpt_state_t state,
    output logic       fail_erase,
    output logic       rb_en_n
);
    rpt_state_t nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_READY: begin
                if (op_busy) nxt = op_is_erase ? ST_ERASE : ST_PROG;
            end
            ST_PROG: begin
                if (op_fail)           nxt = ST_FAIL;
                else if (!op_busy)     nxt = op_suspended ? ST_SUSP : ST_READY;
            end
            ST_ERASE: begin
                if (op_fail)           nxt = ST_FAIL;
                else if (op_suspended) nxt = ST_SUSP;
                else if (!op_busy)     nxt = ST_READY;
            end
            ST_SUSP: begin
                if (op_busy && !op_is_erase)                       nxt = ST_PROG;
                else if (!op_suspended && op_busy && op_is_erase)  nxt = ST_ERASE;
                else if (!op_suspended && !op_busy)                nxt = ST_READY;
            end
            ST_FAIL: nxt = ST_FAIL;
            default: nxt = ST_READY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_READY;
            fail_erase <= 1'b0;
        end else begin
            state <= nxt;
            if (nxt == ST_FAIL && state != ST_FAIL)
                fail_erase <= (state == ST_ERASE);
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_PROG, ST_ERASE, ST_FAIL: rb_en_n = 1'b0;
            default:                    rb_en_n = 1'b1;
        endcase
    end

    a_r9_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FAIL) |=> (state == ST_FAIL));
endmodule

// File: rtl/opst_word.sv
module opst_word
    import op_status_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  rpt_state_t        state,
    input  logic              rd_strobe,
    input  logic              sel_erase,
    input  logic              tgt_bit,
    input  logic              window_closed,
    input  logic              fail_erase,
    output logic [DATA_W-1:0] status_word,
    output logic              use_status
);
    logic tog6, tog2;
    logic flip6, flip2;

    assign flip6 = rd_strobe && (state inside {ST_PROG, ST_ERASE, ST_FAIL});
    assign flip2 = rd_strobe && sel_erase && (state inside {ST_ERASE, ST_SUSP});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tog6 <= 1'b0;
            tog2 <= 1'b0;
        end else begin
            if (flip6) tog6 <= ~tog6;
            if (flip2) tog2 <= ~tog2;
        end
    end

    always_comb begin
        status_word = '0;
        use_status  = 1'b0;
        status_word[BIT_TOGGLE]  = tog6;
        status_word[BIT_ETOGGLE] = tog2;
        unique case (state)
            ST_READY: use_status = 1'b0;
            ST_PROG: begin
                use_status = 1'b1;
                status_word[BIT_POLL] = ~tgt_bit;
            end
            ST_ERASE: begin
                use_status = 1'b1;
                status_word[BIT_WINDOW] = window_closed;
            end
            ST_SUSP: begin
                use_status = sel_erase;
                status_word[BIT_POLL]   = 1'b1;
                status_word[BIT_WINDOW] = window_closed;
            end
            ST_FAIL: begin
                use_status = 1'b1;
                status_word[BIT_POLL] = fail_erase ? 1'b0 : ~tgt_bit;
                status_word[BIT_FAIL] = 1'b1;
            end
            default: use_status = 1'b0;
        endcase
    end

    a_r8_susp_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SUSP) |=> $stable(tog6));
    a_r7_prog_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROG) |=> $stable(tog2));
endmodule

// File: rtl/op_status_reporter.sv
module op_status_reporter
    import op_status_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_busy,
    input  logic              op_is_erase,
    input  logic              op_suspended,
    input  logic              op_fail,
    input  logic              tgt_bit,
    input  logic              window_closed,
    input  logic              rd_strobe,
    input  logic              sel_erase,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              rd_is_status,
    output logic              rb_en_n,
    output logic              rb_zero
);
    localparam int CHK_W = (DATA_W >= MIN_W) ? 1 : 0;

    rpt_state_t        state;
    logic              fail_erase;
    logic [DATA_W-1:0] status_word;
    logic              use_status;
    logic              chk_armed;

    opst_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .op_busy(op_busy), .op_is_erase(op_is_erase),
        .op_suspended(op_suspended), .op_fail(op_fail),
        .state(state), .fail_erase(fail_erase), .rb_en_n(rb_en_n)
    );

    opst_word #(.DATA_W(DATA_W)) u_word (
        .clk(clk), .rst_n(rst_n), .state(state),
        .rd_strobe(rd_strobe), .sel_erase(sel_erase),
        .tgt_bit(tgt_bit), .window_closed(window_closed),
        .fail_erase(fail_erase),
        .status_word(status_word), .use_status(use_status)
    );

    assign rb_zero = 1'b0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data      <= '0;
            rd_valid     <= 1'b0;
            rd_is_status <= 1'b0;
            chk_armed    <= 1'b0;
        end else begin
            chk_armed <= 1'b1;
            rd_valid  <= rd_strobe;
            if (rd_strobe) begin
                rd_data      <= use_status ? status_word : arr_data;
                rd_is_status <= use_status;
            end else begin
                rd_is_status <= 1'b0;
            end
        end
    end

    initial a_r2_width_ok: assert (CHK_W == 1);

    a_r2_array_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_is_status) |-> (rd_data == $past(arr_data)));
    a_r2_status_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_is_status |-> rd_valid);
    a_r3_busy_low: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_armed && $past(op_busy) && !$past(op_suspended)) |-> !rb_en_n);
endmodule

// File: tb/test_op_status_reporter.sv
module test_op_status_reporter;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_busy, op_is_erase, op_suspended, op_fail;
    logic        tgt_bit, window_closed, rd_strobe, sel_erase;
    logic [15:0] arr_data;
    logic [15:0] rd_data;
    logic        rd_valid, rd_is_status, rb_en_n, rb_zero;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic m6 = 1'b0;   // expected toggle bit 6
    logic m2 = 1'b0;   // expected toggle bit 2

    always #2 clk = ~clk;

    op_status_reporter #(.DATA_W(16)) i_op_status_reporter (
        .clk(clk), .rst_n(rst_n), .op_busy(op_busy), .op_is_erase(op_is_erase),
        .op_suspended(op_suspended), .op_fail(op_fail), .tgt_bit(tgt_bit),
        .window_closed(window_closed), .rd_strobe(rd_strobe), .sel_erase(sel_erase),
        .arr_data(arr_data), .rd_data(rd_data), .rd_valid(rd_valid),
        .rd_is_status(rd_is_status), .rb_en_n(rb_en_n), .rb_zero(rb_zero)
    );

    function automatic logic [15:0] sw(logic b7, logic b6, logic b5, logic b3, logic b2);
        logic [15:0] w;
        w = '0;
        w[7] = b7; w[6] = b6; w[5] = b5; w[3] = b3; w[2] = b2;
        return w;
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // read issued at a negedge, answer sampled one negedge later
    task automatic rd(input logic sel, input logic [15:0] arr,
                      output logic [15:0] d, output logic st, output logic v);
        rd_strobe = 1'b1; sel_erase = sel; arr_data = arr;
        @(negedge clk);
        rd_strobe = 1'b0;
        d = rd_data; st = rd_is_status; v = rd_valid;
    endtask

    task automatic read_array(input string req, input logic sel, input logic [15:0] arr);
        logic [15:0] d; logic st, v;
        rd(sel, arr, d, st, v);
        chk({req, " valid"}, {15'd0, v}, 16'd1);
        chk({req, " array flag"}, {15'd0, st}, 16'd0);
        chk({req, " array data"}, d, arr);
    endtask

    task automatic read_status(input string req, input logic sel, input logic [15:0] exp);
        logic [15:0] d; logic st, v;
        rd(sel, 16'h5AA5, d, st, v);
        chk({req, " status flag"}, {15'd0, st}, 16'd1);
        chk({req, " status word"}, d, exp);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        op_busy = 0; op_is_erase = 0; op_suspended = 0; op_fail = 0;
        tgt_bit = 0; window_closed = 0; rd_strobe = 0; sel_erase = 0; arr_data = '0;
        m6 = 0; m2 = 0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        chk("R1 valid", {15'd0, rd_valid}, 16'd0);
        chk("R1 rb_en_n", {15'd0, rb_en_n}, 16'd1);
        chk("R1 rb_zero", {15'd0, rb_zero}, 16'd0);
    endtask

    task automatic t_ready;
        read_array("R2 ready", 1'b0, 16'hA5C3);
        read_array("R2 ready sel", 1'b1, 16'h1234);
    endtask

    task automatic t_program;
        op_busy = 1; op_is_erase = 0; tgt_bit = 1;
        tick(1);
        chk("R3 busy in prog", {15'd0, rb_en_n}, 16'd0);
        read_status("R4 R5 prog read1 (R1 first toggle)", 1'b0, sw(0, m6, 0, 0, m2)); m6 = ~m6;
        read_status("R5 prog read2", 1'b1, sw(0, m6, 0, 0, m2)); m6 = ~m6;
        tgt_bit = 0;
        read_status("R4 prog inverted bit", 1'b0, sw(1, m6, 0, 0, m2)); m6 = ~m6;
        op_busy = 0;
        tick(1);
        chk("R3 ready after prog", {15'd0, rb_en_n}, 16'd1);
        read_array("R10 true data after prog", 1'b0, 16'hBEEF);
    endtask

    task automatic t_erase;
        op_busy = 1; op_is_erase = 1; window_closed = 0;
        tick(1);
        chk("R3 busy in erase", {15'd0, rb_en_n}, 16'd0);
        read_status("R6 R7 erase sel", 1'b1, sw(0, m6, 0, 0, m2)); m6 = ~m6; m2 = ~m2;
        read_status("R7 erase unsel", 1'b0, sw(0, m6, 0, 0, m2)); m6 = ~m6;
        window_closed = 1;
        read_status("R6 window", 1'b1, sw(0, m6, 0, 1, m2)); m6 = ~m6; m2 = ~m2;
    endtask

    task automatic t_suspend;
        op_suspended = 1; op_busy = 0;
        tick(1);
        chk("R3 ready in suspend", {15'd0, rb_en_n}, 16'd1);
        read_array("R8 susp unsel", 1'b0, 16'h0F0F);
        read_status("R8 susp sel1", 1'b1, sw(1, m6, 0, 1, m2)); m2 = ~m2;
        read_status("R8 R7 susp sel2", 1'b1, sw(1, m6, 0, 1, m2)); m2 = ~m2;
        // program inside suspend
        op_busy = 1; op_is_erase = 0; tgt_bit = 1;
        tick(1);
        chk("R11 busy prog in susp", {15'd0, rb_en_n}, 16'd0);
        read_status("R11 prog in susp unsel", 1'b0, sw(0, m6, 0, 0, m2)); m6 = ~m6;
        op_busy = 0;
        tick(1);
        read_array("R11 back to susp", 1'b0, 16'h7E81);
        // resume
        op_suspended = 0; op_busy = 1; op_is_erase = 1;
        tick(1);
        chk("R11 resume busy", {15'd0, rb_en_n}, 16'd0);
        read_status("R11 resume erase", 1'b0, sw(0, m6, 0, 1, m2)); m6 = ~m6;
        op_busy = 0;
        tick(1);
        read_array("R10 true data after erase", 1'b1, 16'hC001);
    endtask

    task automatic t_fail;
        op_busy = 1; op_is_erase = 0; tgt_bit = 0;
        tick(1);
        op_fail = 1;
        tick(1);
        op_fail = 0; op_busy = 0;
        tick(3);
        chk("R9 still busy", {15'd0, rb_en_n}, 16'd0);
        read_status("R9 fail unsel", 1'b0, sw(1, m6, 1, 0, m2)); m6 = ~m6;
        read_status("R9 R5 fail sel", 1'b1, sw(1, m6, 1, 0, m2)); m6 = ~m6;
        rst_n = 0;
        tick(1);
        rst_n = 1;
        tick(1);
        chk("R9 reset clears", {15'd0, rb_en_n}, 16'd1);
        m6 = 0; m2 = 0;
        read_array("R1 R9 array after reset", 1'b0, 16'h3C3C);
    endtask

    initial begin
        t_reset();
        t_ready();
        t_program();
        t_erase();
        t_suspend();
        t_fail();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #40000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got hang expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule